// File: doc/BRIEF.md
# Serial Packet Preamble Detector

This block watches a demodulated serial bit stream at a base-station receiver. Three asynchronous lines come in: a recovered bit clock, a data line and a valid-data flag from the radio. All three are brought into the system clock domain. On each rising edge of the bit clock the current data bit enters a shift window. When the window holds the tail of the preamble followed by the sync word, and the valid flag is high, the trailing byte is taken as a payload.

An accepted payload goes to a display register and is offered downstream on a valid/ready handshake. A packet-absence watchdog lights an LED output when no packet has been accepted for a set number of system cycles. The LED goes dark again at the next accepted packet.

The controller has two states. **SEARCH** waits for a qualified match. The transition **SEARCH→COMMUNICATE (accept)** happens on a match with the valid flag high. On that edge the payload is latched into both outputs, the window is cleared and the watchdog is restarted. **COMMUNICATE** drives the byte valid flag. The transition **COMMUNICATE→SEARCH (handed off)** happens when the downstream ready is high. While the controller is in COMMUNICATE the window keeps shifting, but a match there is not acted on.

Top module: `pkt_hunter`

## Requirements
- R1: After reset, `byte_valid` is 0, `nopkt_led` is 0 and `disp_byte` is 0.
- R2: Bits are taken MSB first on each rising edge of `bit_clk`, after a two-stage synchronizer. With the default parameters, a 24-bit frame of preamble, sync and payload is accepted when the preamble's five low bits are 01010 and the sync byte is 0xDB. The three upper preamble bits are ignored, so a preamble of 0x4A is accepted like 0xAA.
- R3: A frame is rejected if any one of the 13 checked bits differs: for example a preamble of 0xAB or 0xA2, or a sync of 0xDA.
- R4: A frame that matches while `bit_valid` is low is not accepted.
- R5: The payload of each accepted frame appears unchanged on `byte_data`, exactly once, with `byte_valid` high until the first cycle in which `byte_ready` is high. All values 0 to 255 are carried, including the step from 255 to 0.
- R6: While `byte_valid` is high and `byte_ready` is low, `byte_valid` stays high and `byte_data` stays stable.
- R7: `disp_byte` takes the payload on acceptance and keeps it through rejected frames.
- R8: The window is emptied on acceptance. Bits received before an accepted frame can therefore never combine with later bits into a match. After payload 0x0A, the bytes 0xDB and 0x55 give no second acceptance.
- R9: `nopkt_led` rises once `WDOG_CYCLES` system cycles pass with no acceptance. It stays high until the next acceptance, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Recovered bit clock from the radio (asynchronous) |
| bit_data | input | 1 | Demodulated data bit (asynchronous) |
| bit_valid | input | 1 | Valid-data flag from the radio (asynchronous) |
| byte_data | output | PAY_W | Payload offered downstream |
| byte_valid | output | 1 | Payload offer qualifier |
| byte_ready | input | 1 | Downstream ready |
| disp_byte | output | PAY_W | Last accepted payload, for the display |
| nopkt_led | output | 1 | High when packets have stopped arriving |

## Verification
The assertions assume that each high and each low phase of `bit_clk` lasts at least three system cycles, so that no synchronized edge is lost. They also assume that `bit_data` and `bit_valid` are settled before the rising bit-clock edge that samples them. The stimulus holds each phase for four to five cycles and changes data four cycles before the edge. After a frame that matches with the valid flag low, the stimulus shifts a further byte before it raises the flag again. This keeps a stale match from being accepted late.

// File: rtl/pkthunt_pkg.sv
package pkthunt_pkg;
    typedef enum logic {
        ST_SEARCH      = 1'b0,
        ST_COMMUNICATE = 1'b1
    } hunt_state_e;
endpackage

// File: rtl/pkthunt_sync.sv
module pkthunt_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/pkthunt_window.sv
module pkthunt_window #(
    parameter int               PRE_CHK  = 5,
    parameter int               SYNC_W   = 8,
    parameter int               PAY_W    = 8,
    parameter logic [PRE_CHK-1:0] PRE_PAT  = 5'b01010,
    parameter logic [SYNC_W-1:0]  SYNC_PAT = 8'hDB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             clear,
    output logic             pat_hit,
    output logic [PAY_W-1:0] payload
);
    localparam int WIN_W = PRE_CHK + SYNC_W + PAY_W;

    logic [WIN_W-1:0] win;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win <= '0;
        end else if (clear) begin
            win <= '0;
        end else if (shift_en) begin
            win <= {win[WIN_W-2:0], bit_in};
        end
    end

    assign payload = win[PAY_W-1:0];
    assign pat_hit = (win[PAY_W +: SYNC_W] == SYNC_PAT) &&
                     (win[PAY_W+SYNC_W +: PRE_CHK] == PRE_PAT);
endmodule

// File: rtl/pkthunt_wdog.sv
module pkthunt_wdog #(
    parameter int unsigned MAX_CYC = 300_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic alarm
);
    localparam int CW = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            alarm <= 1'b0;
        end else if (kick) begin
            cnt   <= '0;
            alarm <= 1'b0;
        end else if (cnt == CW'(MAX_CYC)) begin
            alarm <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pkt_hunter.sv
module pkt_hunter #(
    parameter int                 PRE_CHK     = 5,
    parameter int                 SYNC_W      = 8,
    parameter int                 PAY_W       = 8,
    parameter logic [PRE_CHK-1:0] PRE_PAT     = 5'b01010,
    parameter logic [SYNC_W-1:0]  SYNC_PAT    = 8'hDB,
    parameter int unsigned        WDOG_CYCLES = 300_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_clk,
    input  logic             bit_data,
    input  logic             bit_valid,
    output logic [PAY_W-1:0] byte_data,
    output logic             byte_valid,
    input  logic             byte_ready,
    output logic [PAY_W-1:0] disp_byte,
    output logic             nopkt_led
);
    import pkthunt_pkg::*;

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in, synced;
    logic             bclk_s, dat_s, vld_s, bclk_d, bit_rise;
    logic             pat_hit, accept;
    logic [PAY_W-1:0] payload;
    hunt_state_e      state_q, state_d;

    assign raw_in = {bit_clk, bit_data, bit_valid};

    pkthunt_sync #(.W(NSYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(raw_in),
        .d_sync (synced)
    );

    assign {bclk_s, dat_s, vld_s} = synced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk_s;
    end

    assign bit_rise = bclk_s & ~bclk_d;

    pkthunt_window #(
        .PRE_CHK (PRE_CHK),
        .SYNC_W  (SYNC_W),
        .PAY_W   (PAY_W),
        .PRE_PAT (PRE_PAT),
        .SYNC_PAT(SYNC_PAT)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(bit_rise),
        .bit_in  (dat_s),
        .clear   (accept),
        .pat_hit (pat_hit),
        .payload (payload)
    );

    pkthunt_wdog #(.MAX_CYC(WDOG_CYCLES)) u_wdog (
        .clk  (clk),
        .rst_n(rst_n),
        .kick (accept),
        .alarm(nopkt_led)
    );

    assign accept = (state_q == ST_SEARCH) && pat_hit && vld_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEARCH:      if (accept)     state_d = ST_COMMUNICATE;
            ST_COMMUNICATE: if (byte_ready) state_d = ST_SEARCH;
            default:                        state_d = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEARCH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_data  <= '0;
            disp_byte  <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= (state_d == ST_COMMUNICATE);
            if (accept) begin
                byte_data <= payload;
                disp_byte <= payload;
            end
        end
    end
endmodule

// File: rtl/pkt_hunter_chk.sv
module pkt_hunter_chk #(
    parameter int PAY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PAY_W-1:0] byte_data,
    input logic             byte_valid,
    input logic             byte_ready,
    input logic [PAY_W-1:0] disp_byte,
    input logic             nopkt_led,
    input logic             accept,
    input logic             vld_s
);
    // R6
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

    // R5
    single_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && byte_ready |=> !byte_valid);

    // R5
    offer_from_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_valid) |-> $past(accept));

    // R4
    valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_valid) |-> $past(vld_s));

    // R7
    disp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_valid) |-> disp_byte == byte_data);

    // R9
    led_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_valid) |-> !nopkt_led);
endmodule

bind pkt_hunter pkt_hunter_chk #(.PAY_W(PAY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_data (byte_data),
    .byte_valid(byte_valid),
    .byte_ready(byte_ready),
    .disp_byte (disp_byte),
    .nopkt_led (nopkt_led),
    .accept    (accept),
    .vld_s     (vld_s)
);

// File: tb/sim_pkt_hunter.sv
`timescale 1ns/1ps
module sim_pkt_hunter;
    localparam int WD = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_clk = 1'b0, bit_data = 1'b0, bit_valid = 1'b0;
    logic [7:0] byte_data, disp_byte;
    logic       byte_valid, nopkt_led;
    logic       byte_ready = 1'b1;

    int   n_chk = 0, n_bad = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    pkt_hunter #(.WDOG_CYCLES(WD)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .bit_data(bit_data),
        .bit_valid(bit_valid), .byte_data(byte_data), .byte_valid(byte_valid),
        .byte_ready(byte_ready), .disp_byte(disp_byte), .nopkt_led(nopkt_led)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic put_bit(input logic b);
        tick(1);
        bit_data = b;
        tick(4);
        bit_clk = 1'b1;
        tick(5);
        bit_clk = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    // driver: pushes the expected payload before the frame goes out
    task automatic send_pkt(input logic [7:0] pre, input logic [7:0] syn,
                            input logic [7:0] pay, input logic vld, input logic expect_ok);
        if (expect_ok) exp_q.push_back(pay);
        tick(1);
        bit_valid = vld;
        put_byte(pre);
        put_byte(syn);
        put_byte(pay);
        tick(8);
        bit_valid = 1'b0;
    endtask

    // monitor: R5 R7 scoreboard on each handshake
    always @(negedge clk) begin
        if (rst_n && byte_valid && byte_ready) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R5 unexpected byte got %0h expected none", byte_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check("R5 payload", byte_data, e);
                check("R7 display", disp_byte, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog got hung expected finish");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check("R1 byte_valid", byte_valid, 0);
        check("R1 nopkt_led", nopkt_led, 0);
        check("R1 disp_byte", disp_byte, 0);

        // R2 R5: nominal frames, payload wraps 255 -> 0
        send_pkt(8'hAA, 8'hDB, 8'd254, 1, 1);
        send_pkt(8'hAA, 8'hDB, 8'd255, 1, 1);
        send_pkt(8'hAA, 8'hDB, 8'd0,   1, 1);
        send_pkt(8'hAA, 8'hDB, 8'd1,   1, 1);
        // R2: upper preamble bits ignored
        send_pkt(8'h4A, 8'hDB, 8'h33, 1, 1);
        // R3: single-bit mismatches
        send_pkt(8'hAB, 8'hDB, 8'h44, 1, 0);
        send_pkt(8'hA2, 8'hDB, 8'h45, 1, 0);
        send_pkt(8'hAA, 8'hDA, 8'h46, 1, 0);
        // R4: match with valid low, then flush a byte
        send_pkt(8'hAA, 8'hDB, 8'h55, 0, 0);
        put_byte(8'h00);
        tick(5);
        check("R7 display kept through rejects", disp_byte, 8'h33);
        check("R3 R4 no pending offer", byte_valid, 0);

        // R8: bits before an acceptance must not form a second match
        send_pkt(8'hAA, 8'hDB, 8'h0A, 1, 1);
        bit_valid = 1'b1;
        put_byte(8'hDB);
        put_byte(8'h55);
        tick(8);
        bit_valid = 1'b0;
        check("R8 no overlap match", byte_valid, 0);
        check("R8 display", disp_byte, 8'h0A);

        // R6: hold while ready low
        byte_ready = 1'b0;
        send_pkt(8'hAA, 8'hDB, 8'h66, 1, 1);
        for (int k = 0; k < 50 && !byte_valid; k++) tick(1);
        held = byte_data;
        check("R6 offer present", byte_valid, 1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!byte_valid || byte_data !== held) begin
                check("R6 hold", {byte_valid, byte_data}, {1'b1, held});
            end
        end
        check("R6 held value", held, 8'h66);
        tick(1);
        byte_ready = 1'b1;
        tick(4);

        // R9: watchdog
        tick(WD - 300);
        check("R9 led before limit", nopkt_led, 0);
        tick(600);
        check("R9 led after limit", nopkt_led, 1);
        send_pkt(8'hAA, 8'hDB, 8'h77, 1, 1);
        check("R9 led cleared", nopkt_led, 0);
        tick(10);
        check("R5 queue drained", exp_q.size(), 0);
        finish_run();
    end
endmodule